// File: doc/BRIEF.md
# Set/Clear Interrupt Mask Controller

This block gathers five event sources into one pending-flag register and raises a single active-low interrupt line. The sources are a timer A underflow, a timer B underflow, a clock alarm, a serial register full/empty event and a falling edge on an external flag pin. Each event sets its own flag, whatever the mask says. The interrupt line only reflects flags whose enable bit is set.

Software changes the enable mask with a single byte write. Bit 7 of that byte selects the action. When it is 1, every enable bit marked by a 1 in bits 0 to 4 is set. When it is 0, those marked bits are cleared. Enable bits marked by 0 keep their value, so each write affects only the sources it names.

A byte read returns the pending flags together with a summary bit. The read then clears every flag, which releases the interrupt line. The timer, alarm and serial events arrive as single-cycle pulses from logic on the same clock. The flag pin is asynchronous and passes through a synchroniser before its falling edge is detected.

Top module: `irq_mask_ctrl`

## Requirements
- R1: A write with bit 7 = 1 sets every enable bit whose position in bits 0..4 holds a 1. All other enable bits keep their value.
- R2: A write with bit 7 = 0 clears every enable bit whose position in bits 0..4 holds a 1. All other enable bits keep their value.
- R3: Each source event latches its flag whether or not that source is enabled. Read data bits 0..4 show the flags in this order: timer A = bit 0, timer B = bit 1, alarm = bit 2, serial = bit 3, flag pin = bit 4. Bits 5 and 6 always read 0.
- R4: Read data bit 7 is 1 exactly when at least one pending flag is also enabled.
- R5: `irq_n` is low exactly when at least one pending flag is also enabled.
- R6: The clock edge that ends a read cycle (`rd_en` high) clears all latched flags, so `irq_n` returns high unless a new enabled event arrives.
- R7: An event that is present in the same cycle as a read is kept as a pending flag after that read.
- R8: A falling edge on `flag_pin_n` passes through a two-stage synchroniser. It sets flag bit 4 at the third clock edge after the pin falls. A rising edge, or a pin held low, sets nothing further.
- R9: After reset the mask and the flags are zero, `rd_data` reads 0x00 and `irq_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_timer_a | input | 1 | Timer A underflow pulse |
| evt_timer_b | input | 1 | Timer B underflow pulse |
| evt_alarm | input | 1 | Clock alarm pulse |
| evt_serial | input | 1 | Serial register full/empty pulse |
| flag_pin_n | input | 1 | Asynchronous external flag pin, falling-edge active |
| wr_en | input | 1 | Mask write strobe |
| wr_data | input | 8 | Write byte: bit 7 selects set/clear, bits 0..4 select enables |
| rd_en | input | 1 | Read strobe; the flags clear at the end of the cycle |
| rd_data | output | 8 | Summary bit 7, pending flags in bits 0..4 |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with its default values: five sources, an 8-bit data byte and a two-stage synchroniser. With these values each source maps to a fixed bit of the byte. The bench can therefore check the exact bit positions. It also checks the three-edge delay of the flag pin, measured from the pin's fall to the flag appearing.

Reads are issued in the same cycle as new events. This shows that the clear does not swallow an event arriving in the read cycle. Set and clear writes are interleaved so that the bench can check that unnamed enable bits keep their value.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned SRC_N  = 5;
    localparam int unsigned BYTE_W = 8;

    // Bit position of each source in the flag and mask vectors
    localparam int unsigned POS_TMR_A = 0;
    localparam int unsigned POS_TMR_B = 1;
    localparam int unsigned POS_ALARM = 2;
    localparam int unsigned POS_SERIAL = 3;
    localparam int unsigned POS_FLAG = 4;

    typedef logic [SRC_N-1:0] src_vec_t;

    typedef struct packed {
        logic                  set_not_clr;
        logic [BYTE_W-SRC_N-2:0] spare;
        src_vec_t              select;
    } mask_cmd_t;

    typedef struct packed {
        logic                  any_active;
        logic [BYTE_W-SRC_N-2:0] zero;
        src_vec_t              pending;
    } status_byte_t;

    function automatic src_vec_t apply_cmd(src_vec_t cur, mask_cmd_t cmd);
        if (cmd.set_not_clr)
            return cur | cmd.select;
        else
            return cur & ~cmd.select;
    endfunction

    function automatic status_byte_t pack_status(src_vec_t flags, src_vec_t mask);
        status_byte_t s;
        s.any_active = |(flags & mask);
        s.zero       = '0;
        s.pending    = flags;
        return s;
    endfunction

endpackage

// File: rtl/irqc_edge_sync.sv
module irqc_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic fall_pulse
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b1;
                    else     chain[g] <= pin_n;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b1;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= chain[LAST];
    end

    assign fall_pulse = prev & ~chain[LAST];

    // R8: a detected fall never lasts more than one cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        fall_pulse |=> !fall_pulse);

endmodule

// File: rtl/irqc_flag_latch.sv
module irqc_flag_latch
    import irqc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t events,
    input  logic     clear,
    output src_vec_t flags
);
    src_vec_t flags_q;

    always_ff @(posedge clk) begin
        if (rst)        flags_q <= '0;
        else if (clear) flags_q <= events;
        else            flags_q <= flags_q | events;
    end

    assign flags = flags_q;

    // R3, R7: every event is visible as a flag after its edge, even during a read
    a_r7_event_kept: assert property (@(posedge clk) disable iff (rst)
        (events != '0) |=> ((flags & $past(events)) == $past(events)));

    // R6: a read with no new event leaves no flag behind
    a_r6_read_clears: assert property (@(posedge clk) disable iff (rst)
        (clear && events == '0) |=> (flags == '0));

    // R3: without a read, flags never drop
    a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
        !clear |=> ((flags & $past(flags)) == $past(flags)));

endmodule

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg
    import irqc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  mask_cmd_t cmd,
    output src_vec_t  mask
);
    src_vec_t mask_q;

    always_ff @(posedge clk) begin
        if (rst)        mask_q <= '0;
        else if (wr_en) mask_q <= apply_cmd(mask_q, cmd);
    end

    assign mask = mask_q;

    // R1: selected bits are set after a set-write
    a_r1_set_bits: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cmd.set_not_clr) |=>
            ((mask & $past(cmd.select)) == $past(cmd.select)));

    // R2: selected bits are cleared after a clear-write
    a_r2_clear_bits: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !cmd.set_not_clr) |=> ((mask & $past(cmd.select)) == '0));

    // R1, R2: unselected bits keep their value
    a_r2_others_kept: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ((mask & ~$past(cmd.select)) == ($past(mask) & ~$past(cmd.select))));

    a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(mask));

endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
    import irqc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_timer_a,
    input  logic              evt_timer_b,
    input  logic              evt_alarm,
    input  logic              evt_serial,
    input  logic              flag_pin_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rd_data,
    output logic              irq_n
);
    src_vec_t     events;
    src_vec_t     flags;
    src_vec_t     mask;
    logic         flag_fall;
    mask_cmd_t    cmd;
    status_byte_t status;
    logic         unused_spare;

    irqc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .pin_n     (flag_pin_n),
        .fall_pulse(flag_fall)
    );

    always_comb begin
        events             = '0;
        events[POS_TMR_A]  = evt_timer_a;
        events[POS_TMR_B]  = evt_timer_b;
        events[POS_ALARM]  = evt_alarm;
        events[POS_SERIAL] = evt_serial;
        events[POS_FLAG]   = flag_fall;
    end

    assign cmd          = mask_cmd_t'(wr_data);
    assign unused_spare = ^cmd.spare;

    irqc_mask_reg u_mask (
        .clk  (clk),
        .rst  (rst),
        .wr_en(wr_en),
        .cmd  (cmd),
        .mask (mask)
    );

    irqc_flag_latch u_flags (
        .clk   (clk),
        .rst   (rst),
        .events(events),
        .clear (rd_en),
        .flags (flags)
    );

    assign status  = pack_status(flags, mask);
    assign rd_data = status;
    assign irq_n   = ~status.any_active;

    // R5: with no enabled source the line stays released
    a_r5_idle_high: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> irq_n);

    // R3: the spare read bits are always zero
    a_r3_spare_zero: assert property (@(posedge clk) disable iff (rst)
        rd_data[BYTE_W-2:SRC_N] == '0);

endmodule

// File: tb/tb_irq_mask_ctrl.sv
module tb_irq_mask_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       evt_timer_a = 1'b0, evt_timer_b = 1'b0, evt_alarm = 1'b0, evt_serial = 1'b0;
    logic       flag_pin_n = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       irq_n;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    irq_mask_ctrl dut (
        .clk(clk), .rst(rst),
        .evt_timer_a(evt_timer_a), .evt_timer_b(evt_timer_b),
        .evt_alarm(evt_alarm), .evt_serial(evt_serial),
        .flag_pin_n(flag_pin_n),
        .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .irq_n(irq_n)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic set_events(logic [3:0] v);
        {evt_serial, evt_alarm, evt_timer_b, evt_timer_a} = v;
    endtask

    task automatic pulse(logic [3:0] v);
        set_events(v);
        @(negedge clk);
        set_events(4'h0);
    endtask

    task automatic write_cmd(logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic read_byte(output logic [7:0] d);
        rd_en = 1'b1;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset;
        check("R9 rd_data", rd_data, 8'h00);
        check("R9 irq_n", {7'd0, irq_n}, 8'h01);
    endtask

    task automatic t_latch_masked;
        logic [7:0] d;
        pulse(4'b0001);
        check("R5 masked irq_n", {7'd0, irq_n}, 8'h01);
        read_byte(d);
        check("R3 timer A bit0, R4 no summary", d, 8'h01);
    endtask

    task automatic t_set;
        logic [7:0] d;
        write_cmd(8'h83);
        pulse(4'b0010);
        check("R5 enabled irq_n low", {7'd0, irq_n}, 8'h00);
        read_byte(d);
        check("R1 R4 timer B with summary", d, 8'h82);
        check("R6 irq_n released", {7'd0, irq_n}, 8'h01);
        read_byte(d);
        check("R6 flags cleared", d, 8'h00);
    endtask

    task automatic t_clear;
        logic [7:0] d;
        write_cmd(8'h01);
        pulse(4'b0001);
        check("R2 cleared source no irq", {7'd0, irq_n}, 8'h01);
        read_byte(d);
        check("R2 R3 timer A latched unmasked", d, 8'h01);
        pulse(4'b0010);
        check("R2 other bit kept enabled", {7'd0, irq_n}, 8'h00);
        read_byte(d);
        check("R2 timer B still enabled", d, 8'h82);
    endtask

    task automatic t_same_cycle;
        logic [7:0] d;
        pulse(4'b1000);
        rd_en = 1'b1; set_events(4'b0100);
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0; set_events(4'h0);
        check("R3 serial bit3", d, 8'h08);
        read_byte(d);
        check("R7 alarm kept across read", d, 8'h04);
    endtask

    task automatic t_flag_pin;
        logic [7:0] d;
        write_cmd(8'h90);
        flag_pin_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R8 not yet after two edges", rd_data, 8'h00);
        @(negedge clk);
        check("R8 set at third edge", rd_data, 8'h90);
        check("R8 R5 irq low", {7'd0, irq_n}, 8'h00);
        read_byte(d);
        repeat (4) @(negedge clk);
        check("R8 held low no retrigger", rd_data, 8'h00);
        flag_pin_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R8 rising edge ignored", rd_data, 8'h00);
    endtask

    task automatic t_all;
        logic [7:0] d;
        write_cmd(8'h9F);
        pulse(4'b1111);
        read_byte(d);
        check("R1 R3 all sources", d, 8'h8F);
        write_cmd(8'h1F);
        pulse(4'b1000);
        check("R2 all cleared irq high", {7'd0, irq_n}, 8'h01);
        read_byte(d);
        check("R4 no summary when masked", d, 8'h08);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_latch_masked();
        t_set();
        t_clear();
        t_same_cycle();
        t_flag_pin();
        t_all();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #100000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule